// File: doc/BRIEF.md
# Carry-Select Adder with Early Carry Selection

This block adds two unsigned operands of a configurable width together with a single incoming carry. It produces the sum word and the outgoing carry in the same cycle. It is purely combinational, so an enclosing pipeline places it between its own registers.

Internally it follows the carry-select idea, but it chooses the carry early. A per-bit half-adder layer first forms a propagate word and a generate word. Two ripple carry chains then run in parallel from those words. One chain assumes the incoming carry is clear. The other assumes it is set, so its bit 0 already includes the propagate term. One carry word is chosen by an AND-OR per bit instead of a multiplexer. This works because wherever the "clear" chain carries, the "set" chain also carries. The chosen carry word, shifted up by one bit, is XORed with the propagate word to form the sum. The incoming carry fills the lowest position of that shifted word.

Top module: `csel_adder`

## Requirements
- R1: For every operand pair and incoming carry, {cout, s} equals the arithmetic value a + b + cin, computed WIDTH+1 bits wide. The outputs follow the inputs with no clock.
- R2: With cin = 0, {cout, s} equals a + b exactly.
- R3: With a all ones, b zero and cin = 1, the carry ripples through every bit, giving s = 0 and cout = 1. With a and b both all ones and cin = 1, the result is s all ones and cout = 1.
- R4: The selected carry word equals the carry-in-0 chain when cin = 0 and the carry-in-1 chain when cin = 1.
- R5: At every bit position, a carry in the carry-in-0 chain implies a carry in the carry-in-1 chain.
- R6: The propagate bit (a XOR b) and the generate bit (a AND b) are never both set at the same position.
- R7: Sum bit 0 equals a[0] XOR b[0] XOR cin.
- R8: The adder is correct for any WIDTH of at least 2. Widths 6, 16 and 32 are exercised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Incoming carry |
| s | output | WIDTH | Sum word |
| cout | output | 1 | Carry out of the top bit |

## Verification
The embedded assertions re-evaluate on every input change. They cover the internal relations that the ports cannot show: the selector tracks the correct chain (R4), the two chains keep their dominance ordering (R5), and the half-adder words stay exclusive (R6). They also compare the full result against arithmetic (R1). Only the bench scenarios show the behaviour across widths. These include an exhaustive sweep at width 6, random vectors at widths 16 and 32, and the full-length ripple corner cases (R3, R8).

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] s,
  output logic             cout
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] hsum, hcar, chain0, chain1, csel;
  logic [WIDTH:0]   ref_total;

  always_comb begin
    hsum = a ^ b;
    hcar = a & b;

    chain0[0] = hcar[0];
    chain1[0] = hcar[0] | hsum[0];
    for (int i = 1; i < WIDTH; i++) begin
      chain0[i] = hcar[i] | (hsum[i] & chain0[i-1]);
      chain1[i] = hcar[i] | (hsum[i] & chain1[i-1]);
    end

    csel = chain0 | ({WIDTH{cin}} & chain1);

    cout = csel[TOP];
    s    = hsum ^ {csel[TOP-1:0], cin};

    ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    AST_TOTAL_MATCH: assert ({cout, s} == ref_total); // R1
    if (!cin) begin
      AST_PICK_ZERO: assert (csel == chain0); // R4
    end else begin
      AST_PICK_ONE: assert (csel == chain1); // R4
    end
    AST_CHAIN_ORDER: assert ((chain0 & ~chain1) == '0); // R5
    AST_HALF_EXCL: assert ((hsum & hcar) == '0); // R6
  end

endmodule

// File: tb/test_csel_adder.sv
module test_csel_adder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [5:0]  a6, b6, s6;
  logic [15:0] a16, b16, s16;
  logic [31:0] a32, b32, s32;
  logic        cin, co6, co16, co32;

  csel_adder #(.WIDTH(6))  i_csel_adder   (.a(a6),  .b(b6),  .cin(cin), .s(s6),  .cout(co6));
  csel_adder #(.WIDTH(16)) i_csel_adder16 (.a(a16), .b(b16), .cin(cin), .s(s16), .cout(co16));
  csel_adder #(.WIDTH(32)) i_csel_adder32 (.a(a32), .b(b32), .cin(cin), .s(s32), .cout(co32));

  typedef struct {
    logic [6:0]  e6;
    logic [16:0] e16;
    logic [32:0] e32;
    logic        lsb;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] x6, input logic [5:0] y6,
                       input logic [15:0] x16, input logic [15:0] y16,
                       input logic [31:0] x32, input logic [31:0] y32,
                       input logic c, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    a6 = x6; b6 = y6; a16 = x16; b16 = y16; a32 = x32; b32 = y32; cin = c;
    it.e6  = {1'b0, x6}  + {1'b0, y6}  + {6'b0, c};
    it.e16 = {1'b0, x16} + {1'b0, y16} + {16'b0, c};
    it.e32 = {1'b0, x32} + {1'b0, y32} + {32'b0, c};
    it.lsb = x6[0] ^ y6[0] ^ c;
    it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check({co6, s6} == it.e6, {it.tag, " w6"}, {26'b0, co6, s6}, {26'b0, it.e6});
      check({co16, s16} == it.e16, {it.tag, " w16 R8"}, {16'b0, co16, s16}, {16'b0, it.e16});
      check({co32, s32} == it.e32, {it.tag, " w32 R8"}, {co32, s32}, it.e32);
      check(s6[0] == it.lsb, "R7 lsb", {32'b0, s6[0]}, {32'b0, it.lsb});
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a6 = '0; b6 = '0; a16 = '0; b16 = '0; a32 = '0; b32 = '0; cin = 1'b0;
    repeat (2) @(negedge clk);
    check({co6, s6} == 7'd0, "R1 idle zero", {26'b0, co6, s6}, 33'd0);
    check({co32, s32} == 33'd0, "R1 idle zero w32", {co32, s32}, 33'd0);
    @(posedge clk);
    rst_n = 1'b1;

    drive('1, '0, '1, '0, '1, '0, 1'b1, "R3 full ripple");
    drive('1, '1, '1, '1, '1, '1, 1'b1, "R3 all ones");
    drive('1, '1, '1, '1, '1, '1, 1'b0, "R2 all ones no cin");
    drive(6'd1, 6'd0, 16'd1, 16'd0, 32'd1, 32'd0, 1'b1, "R7 lsb carry");
    drive(6'h2a, 6'h15, 16'haaaa, 16'h5555, 32'haaaa_aaaa, 32'h5555_5555, 1'b1, "R3 alternating");

    for (int v = 0; v < 8192; v++) begin
      logic [5:0] x, y;
      logic c;
      x = v[5:0];
      y = v[11:6];
      c = v[12];
      drive(x, y, 16'($urandom), 16'($urandom), $urandom, $urandom, c, c ? "R1 sweep" : "R2 sweep");
    end

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule